// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block sits between the priority logic of an eight-level interrupt controller and the processor data bus. It counts the acknowledge pulses of an interrupt cycle and, for each pulse, decides whether this device drives the bus and which byte it drives. The priority resolver supplies the winning level and a valid flag. The sequencer returns a freeze request that holds that level stable, and a strobe that sets the matching in-service bit.

There are two processor modes. In call mode, three pulses carry a call opcode, a low address byte and a high address byte. In two-pulse mode, the first pulse only freezes priority and the second carries an 8-bit type code. In a cascaded system the master places the slave identity on three cascade lines, and only the addressed slave supplies the later bytes. When polling is pending, a read stands in for the acknowledge cycle and returns the level. A sequence that stalls part-way is abandoned after a programmable idle count.

All inputs are sampled on `clk`. The acknowledge and read strobes are active-high levels held for at least one clock.

Top module: `irq_ack_seq`

## Requirements
- R1: In call mode (`mode_2p`=0), a master drives 0xCD during the first acknowledge pulse. A slave never drives during the first pulse.
- R2: The second call-mode byte is `{vec_lo[7:5], level, 2'b00}` when `ival4`=1, and `{vec_lo[7:6], level, 3'b000}` when `ival4`=0.
- R3: The third call-mode byte is `vec_hi` unchanged.
- R4: In two-pulse mode (`mode_2p`=1), the first pulse drives nothing. The second pulse drives `{vec_hi[7:3], level}` whatever the value of `ival4`.
- R5: With `aeoi`=1, `eoi_auto` pulses for one clock on the trailing edge of the last pulse: the third in call mode, the second in two-pulse mode. With `aeoi`=0 it never pulses.
- R6: A master whose captured level has its `casc_reg` bit set drives that level on `cas_out` from the end of the first pulse to the end of the last pulse. At all other times `cas_out` is 0. `cas_oe` equals `is_master`.
- R7: A master does not drive the later bytes for a level whose `casc_reg` bit is set. A slave drives the later bytes only while `cas_in` equals `casc_reg[2:0]`.
- R8: While `poll_pend`=1, a read returns `{valid, 4'b0000, level}`, with the level field 0 when nothing is valid. The read pulses `isr_set` if the level is valid.
- R9: `buf_en` is high exactly when `buffered`=1 and `dout_en`=1.
- R10: `isr_set` pulses once, at the start of the first pulse, when `lvl_vld`=1. With `lvl_vld`=0 it does not pulse, and the vector and cascade fields use level 7.
- R11: `freeze` is high from the start of the first pulse until the trailing edge of the last pulse, and while `poll_pend`=1.
- R12: If no pulse arrives for `TMO_CYC` clocks in the middle of a sequence, the sequence is dropped. The next pulse is treated as a first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ack | input | 1 | Acknowledge strobe, high during a pulse |
| rd | input | 1 | Read strobe, used for polling |
| poll_pend | input | 1 | A poll command is pending |
| lvl | input | 3 | Resolved highest level |
| lvl_vld | input | 1 | A resolved level exists |
| mode_2p | input | 1 | 1 = two-pulse mode, 0 = call mode |
| ival4 | input | 1 | 1 = interval 4, 0 = interval 8 |
| vec_lo | input | 8 | Low vector base byte |
| vec_hi | input | 8 | High vector base byte, or type base in two-pulse mode |
| casc_reg | input | 8 | Slave bitmap (master) or identity in bits 2:0 (slave) |
| is_master | input | 1 | Device acts as master |
| buffered | input | 1 | Buffered bus option |
| aeoi | input | 1 | Automatic end-of-interrupt enable |
| cas_in | input | 3 | Cascade lines seen by a slave |
| dout | output | 8 | Data byte |
| dout_en | output | 1 | Data output enable |
| buf_en | output | 1 | External buffer enable |
| freeze | output | 1 | Hold the resolver result |
| isr_set | output | 1 | Set the in-service bit for the level |
| eoi_auto | output | 1 | Automatic non-specific end of interrupt |
| cas_out | output | 3 | Cascade lines driven by a master |
| cas_oe | output | 1 | Cascade line direction, 1 = drive |

## Verification
The hardest state to reach from the ports is a stalled sequence. The stimulus gives only the first pulse, then holds the strobe low beyond the idle limit, and then starts a complete fresh sequence. That sequence must begin with the opcode byte again and not carry on with the low address byte. Cascade behaviour needs the role, the slave bitmap and the cascade inputs set together. A slave is checked both with a matching identity and with a wrong one, so that both "drive" and "stay silent" appear on later pulses.

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
  parameter int TMO_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack,
  input  logic       rd,
  input  logic       poll_pend,
  input  logic [2:0] lvl,
  input  logic       lvl_vld,
  input  logic       mode_2p,
  input  logic       ival4,
  input  logic [7:0] vec_lo,
  input  logic [7:0] vec_hi,
  input  logic [7:0] casc_reg,
  input  logic       is_master,
  input  logic       buffered,
  input  logic       aeoi,
  input  logic [2:0] cas_in,
  output logic [7:0] dout,
  output logic       dout_en,
  output logic       buf_en,
  output logic       freeze,
  output logic       isr_set,
  output logic       eoi_auto,
  output logic [2:0] cas_out,
  output logic       cas_oe
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [7:0] CALL_OP = 8'hCD;

  logic          ack_q, rd_q, seq_act, cas_drv;
  logic [1:0]    cnt;
  logic [2:0]    cur_lvl;
  logic [TW-1:0] idle;

  wire       ack_rise = ack & ~ack_q;
  wire       ack_fall = ~ack & ack_q;
  wire       rd_rise  = rd & ~rd_q;
  wire [1:0] last_idx = mode_2p ? 2'd1 : 2'd2;
  wire       last_fall = ack_fall & seq_act & (cnt == last_idx);
  wire       tmo      = seq_act & ~ack & (idle == TW'(TMO_CYC - 1));
  wire [2:0] pick     = lvl_vld ? lvl : 3'd7;
  wire       later_ok = is_master ? ~casc_reg[cur_lvl] : (cas_in == casc_reg[2:0]);

  always_comb begin
    dout    = 8'h00;
    dout_en = 1'b0;
    if (poll_pend && rd) begin
      dout_en = 1'b1;
      dout    = {lvl_vld, 4'b0000, lvl_vld ? lvl : 3'd0};
    end else if (ack) begin
      case (cnt)
        2'd0: begin
          dout_en = ~mode_2p & is_master;
          dout    = CALL_OP;
        end
        2'd1: begin
          dout_en = later_ok;
          if (mode_2p)    dout = {vec_hi[7:3], cur_lvl};
          else if (ival4) dout = {vec_lo[7:5], cur_lvl, 2'b00};
          else            dout = {vec_lo[7:6], cur_lvl, 3'b000};
        end
        default: begin
          dout_en = later_ok & ~mode_2p;
          dout    = vec_hi;
        end
      endcase
    end
  end

  assign buf_en   = buffered & dout_en;
  assign freeze   = seq_act | ack | poll_pend;
  assign isr_set  = lvl_vld & ((ack_rise & ~seq_act) | (rd_rise & poll_pend));
  assign eoi_auto = aeoi & last_fall;
  assign cas_out  = cas_drv ? cur_lvl : 3'd0;
  assign cas_oe   = is_master;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rd_q    <= 1'b0;
      seq_act <= 1'b0;
      cas_drv <= 1'b0;
      cnt     <= 2'd0;
      cur_lvl <= 3'd0;
      idle    <= '0;
    end else begin
      ack_q <= ack;
      rd_q  <= rd;
      if (tmo) begin
        seq_act <= 1'b0;
        cas_drv <= 1'b0;
        cnt     <= 2'd0;
        idle    <= '0;
      end else begin
        idle <= (seq_act && !ack) ? idle + 1'b1 : '0;
        if (ack_rise && !seq_act) begin
          seq_act <= 1'b1;
          cnt     <= 2'd0;
          cur_lvl <= pick;
        end
        if (ack_fall && seq_act) begin
          if (cnt == last_idx) begin
            seq_act <= 1'b0;
            cas_drv <= 1'b0;
            cnt     <= 2'd0;
          end else begin
            cnt <= cnt + 2'd1;
            if (cnt == 2'd0) cas_drv <= is_master & casc_reg[cur_lvl];
          end
        end
      end
    end
  end
endmodule

// File: rtl/irq_ack_seq_chk.sv
module irq_ack_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic       rd,
  input logic       dout_en,
  input logic       freeze,
  input logic       isr_set,
  input logic       eoi_auto,
  input logic [2:0] cas_out,
  input logic       cas_oe
);
  AST_ISR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) isr_set |=> !isr_set); // R10
  AST_EOI_ENDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n) eoi_auto |=> !freeze || ack); // R5
  AST_CAS_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n) (cas_out != 3'd0) |-> freeze); // R6
  AST_CAS_DIR: assert property (@(posedge clk) disable iff (!rst_n) (cas_out != 3'd0) |-> cas_oe); // R6
  AST_DRIVE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n) dout_en |-> (ack || rd)); // R8
endmodule

bind irq_ack_seq irq_ack_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ack(ack), .rd(rd), .dout_en(dout_en),
  .freeze(freeze), .isr_set(isr_set), .eoi_auto(eoi_auto),
  .cas_out(cas_out), .cas_oe(cas_oe)
);

// File: tb/irq_ack_seq_tb.sv
module irq_ack_seq_tb_top;
  localparam int TCK = 10;
  localparam int TMO = 16;

  logic clk = 0, rst_n = 0, ack = 0, rd = 0, poll_pend = 0, lvl_vld = 0;
  logic mode_2p = 0, ival4 = 0, is_master = 1, buffered = 0, aeoi = 0;
  logic [2:0] lvl = 0, cas_in = 0;
  logic [7:0] vec_lo = 0, vec_hi = 0, casc_reg = 0;
  logic [7:0] dout;
  logic dout_en, buf_en, freeze, isr_set, eoi_auto, cas_oe;
  logic [2:0] cas_out;

  irq_ack_seq #(.TMO_CYC(TMO)) dut_i (.*);

  always #(TCK/2) clk = ~clk;

  typedef struct {logic en; logic [7:0] b; logic [2:0] cas; logic be; string tag;} exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0, eoi_n = 0, isr_n = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) begin
    if (eoi_auto) eoi_n++;
    if (isr_set) isr_n++;
  end

  task automatic pulse(input logic en, input logic [7:0] b, input logic [2:0] cas, input string tag);
    exp_t e;
    e.en = en; e.b = b; e.cas = cas; e.be = en & buffered; e.tag = tag;
    q.push_back(e);
    @(negedge clk) ack = 1;
    @(negedge clk) ack = 0;
    @(negedge clk);
  endtask

  initial forever begin
    exp_t e;
    @(posedge ack);
    #(TCK/4);
    if (q.size() == 0) chk(0, "queue", 0, 1);
    else begin
      e = q.pop_front();
      chk(dout_en == e.en, {e.tag, " enable"}, dout_en, e.en);
      if (e.en) chk(dout == e.b, {e.tag, " byte"}, dout, e.b);
      chk(cas_out == e.cas, {e.tag, " cascade"}, cas_out, e.cas);
      chk(buf_en == e.be, {e.tag, " R9 buffer"}, buf_en, e.be);
    end
  end

  task automatic idle_chk(input string req);
    @(negedge clk);
    chk(freeze == 0, {req, " freeze"}, freeze, 0);
    chk(cas_out == 0, {req, " cas idle"}, cas_out, 0);
  endtask

  initial begin
    #(TCK * 200000);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int e0, i0;
    repeat (3) @(negedge clk);
    chk(dout_en == 0 && freeze == 0 && cas_out == 0 && isr_set == 0, "reset", {dout_en, freeze, cas_out}, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R3 R5 R9 R10 R11: call mode, interval 4, auto EOI, buffered
    lvl = 3; lvl_vld = 1; ival4 = 1; vec_lo = 8'hA0; vec_hi = 8'h12; aeoi = 1; buffered = 1;
    e0 = eoi_n; i0 = isr_n;
    pulse(1, 8'hCD, 0, "R1 opcode");
    chk(freeze == 1, "R11 freeze between pulses", freeze, 1);
    pulse(1, 8'hAC, 0, "R2 interval4");
    pulse(1, 8'h12, 0, "R3 high byte");
    chk(eoi_n == e0 + 1, "R5 eoi call", eoi_n - e0, 1);
    chk(isr_n == i0 + 1, "R10 isr set", isr_n - i0, 1);
    idle_chk("R11");

    // R2 R5: interval 8, no auto EOI
    buffered = 0; aeoi = 0; ival4 = 0; vec_lo = 8'h40; lvl = 6; e0 = eoi_n;
    pulse(1, 8'hCD, 0, "R1 opcode");
    pulse(1, 8'h70, 0, "R2 interval8");
    pulse(1, 8'h12, 0, "R3 high byte");
    chk(eoi_n == e0, "R5 no eoi", eoi_n - e0, 0);
    idle_chk("R11");

    // R4 R5: two-pulse mode, interval setting ignored
    mode_2p = 1; ival4 = 1; vec_hi = 8'h48; lvl = 5; aeoi = 1; e0 = eoi_n;
    pulse(0, 8'h00, 0, "R4 first silent");
    chk(eoi_n == e0, "R5 no eoi after first", eoi_n - e0, 0);
    pulse(1, 8'h4D, 0, "R4 type byte");
    chk(eoi_n == e0 + 1, "R5 eoi two-pulse", eoi_n - e0, 1);
    idle_chk("R11");
    aeoi = 0; mode_2p = 0;

    // R6 R7: master with a slave on level 4
    casc_reg = 8'h10; lvl = 4; vec_hi = 8'h12;
    pulse(1, 8'hCD, 0, "R6 opcode no cas yet");
    chk(cas_oe == 1, "R6 cas direction master", cas_oe, 1);
    pulse(0, 8'h00, 4, "R7 master silent R6 cas");
    pulse(0, 8'h00, 4, "R7 master silent R6 cas");
    idle_chk("R6");

    // R7: slave with identity 3
    is_master = 0; casc_reg = 8'h03; cas_in = 3; lvl = 2; ival4 = 1; vec_lo = 8'hA0;
    pulse(0, 8'h00, 0, "R1 slave first silent");
    chk(cas_oe == 0, "R6 cas direction slave", cas_oe, 0);
    pulse(1, 8'hA8, 0, "R7 slave match low");
    pulse(1, 8'h12, 0, "R7 slave match high");
    cas_in = 5;
    pulse(0, 8'h00, 0, "R7 slave first");
    pulse(0, 8'h00, 0, "R7 slave mismatch");
    pulse(0, 8'h00, 0, "R7 slave mismatch");
    is_master = 1; casc_reg = 8'h00; cas_in = 0;

    // R10: no valid request gives level 7
    lvl_vld = 0; lvl = 2; ival4 = 0; vec_lo = 8'hC0; i0 = isr_n;
    pulse(1, 8'hCD, 0, "R10 opcode");
    pulse(1, 8'hF8, 0, "R10 level 7 vector");
    pulse(1, 8'h12, 0, "R10 high");
    chk(isr_n == i0, "R10 no isr", isr_n - i0, 0);

    // R8: poll read
    lvl_vld = 1; lvl = 5; i0 = isr_n;
    @(negedge clk) poll_pend = 1;
    #1 chk(freeze == 1, "R11 poll freeze", freeze, 1);
    @(negedge clk) rd = 1;
    #1 chk(dout_en == 1 && dout == 8'h85, "R8 poll byte", {dout_en, dout}, 9'h185);
    @(negedge clk) rd = 0; poll_pend = 0;
    chk(isr_n == i0 + 1, "R8 poll isr", isr_n - i0, 1);
    lvl_vld = 0;
    @(negedge clk) poll_pend = 1; rd = 1;
    #1 chk(dout == 8'h00, "R8 poll empty", dout, 0);
    @(negedge clk) rd = 0; poll_pend = 0;
    lvl_vld = 1;

    // R12: stall after first pulse, then restart
    lvl = 1; ival4 = 1; vec_lo = 8'hA0;
    pulse(1, 8'hCD, 0, "R12 first");
    repeat (TMO + 8) @(negedge clk);
    chk(freeze == 0, "R12 dropped", freeze, 0);
    pulse(1, 8'hCD, 0, "R12 restart opcode");
    pulse(1, 8'hA4, 0, "R12 low");
    pulse(1, 8'h12, 0, "R12 high");
    idle_chk("R12");

    chk(q.size() == 0, "queue drained", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule